// File: doc/BRIEF.md
# Accumulator Processor Execution Core

This block is a multicycle 16-bit accumulator processor with hardwired control. It keeps a program counter, an accumulator, a stack pointer and an instruction register. It fetches one 16-bit instruction word at a time from a word-addressed synchronous memory and executes it. Every instruction has a 4-bit opcode in bits 15:12 and a 12-bit operand field in bits 11:0.

The operand field can name an absolute address, an offset from the stack pointer, or a constant. Opcode 4'hF is an escape: its remaining bits select a stack or register operation.

The core drives a 12-bit word address, a write-data bus and separate read and write strobes. The memory samples these at the rising clock edge. When the read strobe was high, the memory presents the read word during the following cycle. The register contents are brought out so that the surrounding logic can observe the architectural state.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high (synchronous, active high), PC and AC read 0, SP reads 12'hFFF, and neither memory strobe is asserted.
- R2: Each instruction begins with a read of the word at PC, and PC advances by one in that same fetch. Instructions that read a data operand (absolute or stack-relative load and subtract, pop, return, indirect push, indirect pop) take 4 clock cycles. All others take 3.
- R3: Opcode 4'h0 loads AC from mem[x], 4'h1 writes AC to mem[x], and 4'h3 sets AC to AC minus mem[x], with the result taken modulo 2^16.
- R4: Opcode 4'h7 loads AC with x, zero-extended to 16 bits.
- R5: Opcodes 4'h8, 4'h9 and 4'hB load, store and subtract as in R3, but at address SP+x modulo 4096.
- R6: Opcode 4'h6 always sets PC to x. The conditional branches test AC as a two's complement value: 4'h4 branches on AC>0, 4'h5 on AC=0, 4'hC on AC<0 and 4'hD on AC≠0. A branch that is not taken leaves the incremented PC.
- R7: Opcode 4'hE decrements SP, writes the incremented PC to mem[SP] and sets PC to x. Word 16'hF800 loads PC from mem[SP] and then increments SP.
- R8: Word 16'hF200 decrements SP and then writes AC to mem[SP]. Word 16'hF400 loads AC from mem[SP] and then increments SP.
- R9: Word 16'hF000 decrements SP and writes mem[AC[11:0]] to mem[SP]. Word 16'hF100 writes mem[SP] to mem[AC[11:0]] and increments SP.
- R10: Word 16'hFA00 exchanges the registers: AC takes SP zero-extended, and SP takes AC[11:0].
- R11: Words 16'hFCyy and 16'hFEyy add and subtract the 8-bit value yy to and from SP, modulo 4096.
- R12: Opcodes 4'h2 and 4'hA, and every 4'hF word not listed above, change nothing except that PC advances. They make no memory access after the fetch.
- R13: The read and write strobes are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Word address to memory |
| mem_rdata | input | 16 | Read word, valid the cycle after a read strobe |
| mem_wdata | output | 16 | Write word |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| pc_out | output | 12 | Program counter |
| ac_out | output | 16 | Accumulator |
| sp_out | output | 12 | Stack pointer |

## Verification
In a single clock edge the core can write memory and also update PC or SP. A call stores the return address, moves SP and redirects PC together. An indirect push writes the word it has just read in the same cycle that SP moves.

Random programs place these instructions densely, including at the SP wrap points near 0 and 12'hFFF. An instruction-level reference model in the bench predicts the cycle count of each instruction. The bench then compares PC, AC and SP after every instruction, and compares the whole memory at the end of each program, so that a lost write or a misordered SP update shows up.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   // control sequence phases
   typedef enum logic [1:0] {
      ST_FETCH = 2'd0,   // present PC, request instruction word
      ST_LATCH = 2'd1,   // capture instruction word
      ST_EXEC  = 2'd2,   // address phase / single-cycle work
      ST_RDATA = 2'd3    // operand word returned
   } cpu_state_e;

   typedef enum logic [4:0] {
      OP_NOP,
      OP_LOAD_ABS, OP_STORE_ABS, OP_SUB_ABS,
      OP_LOAD_REL, OP_STORE_REL, OP_SUB_REL,
      OP_LOAD_IMM,
      OP_BR_ALWAYS, OP_BR_GT, OP_BR_EQ, OP_BR_LT, OP_BR_NE,
      OP_CALL, OP_RETURN,
      OP_PUSH_AC, OP_POP_AC, OP_PUSH_IND, OP_POP_IND,
      OP_XCHG, OP_SP_ADD, OP_SP_SUB
   } op_kind_e;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
   import acc_cpu_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 12
) (
   input  logic [DW-1:0] instr,
   output op_kind_e      kind,
   output logic          two_phase,
   output logic [AW-1:0] field,
   output logic [AW-1:0] sp_step
);
   localparam int IMMW = AW - 4;

   logic [3:0]      opc;
   logic [3:0]      sub;
   logic [IMMW-1:0] low;
   logic            low_zero;

   always_comb begin
      opc      = instr[DW-1 -: 4];
      field    = instr[AW-1:0];
      sub      = instr[AW-1 -: 4];
      low      = instr[IMMW-1:0];
      low_zero = (low == '0);
      sp_step  = {4'b0000, low};
   end

   always_comb begin
      kind = OP_NOP;
      case (opc)
         4'h0: kind = OP_LOAD_ABS;
         4'h1: kind = OP_STORE_ABS;
         4'h3: kind = OP_SUB_ABS;
         4'h4: kind = OP_BR_GT;
         4'h5: kind = OP_BR_EQ;
         4'h6: kind = OP_BR_ALWAYS;
         4'h7: kind = OP_LOAD_IMM;
         4'h8: kind = OP_LOAD_REL;
         4'h9: kind = OP_STORE_REL;
         4'hB: kind = OP_SUB_REL;
         4'hC: kind = OP_BR_LT;
         4'hD: kind = OP_BR_NE;
         4'hE: kind = OP_CALL;
         4'hF: begin
            case (sub)
               4'h0: kind = low_zero ? OP_PUSH_IND : OP_NOP;
               4'h1: kind = low_zero ? OP_POP_IND  : OP_NOP;
               4'h2: kind = low_zero ? OP_PUSH_AC  : OP_NOP;
               4'h4: kind = low_zero ? OP_POP_AC   : OP_NOP;
               4'h8: kind = low_zero ? OP_RETURN   : OP_NOP;
               4'hA: kind = low_zero ? OP_XCHG     : OP_NOP;
               4'hC: kind = OP_SP_ADD;
               4'hE: kind = OP_SP_SUB;
               default: kind = OP_NOP;
            endcase
         end
         default: kind = OP_NOP;
      endcase
   end

   // instructions that need a second cycle for returned read data
   always_comb begin
      case (kind)
         OP_LOAD_ABS, OP_SUB_ABS, OP_LOAD_REL, OP_SUB_REL,
         OP_POP_AC, OP_RETURN, OP_PUSH_IND, OP_POP_IND: two_phase = 1'b1;
         default:                                        two_phase = 1'b0;
      endcase
   end

endmodule

// File: rtl/acc_cpu_cond.sv
module acc_cpu_cond
   import acc_cpu_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [DW-1:0] ac,
   input  op_kind_e      kind,
   output logic          taken
);
   logic is_neg;
   logic is_zero;

   always_comb begin
      is_neg  = ac[DW-1];
      is_zero = (ac == '0);
      case (kind)
         OP_BR_ALWAYS: taken = 1'b1;
         OP_BR_GT:     taken = !is_neg && !is_zero;
         OP_BR_EQ:     taken = is_zero;
         OP_BR_LT:     taken = is_neg;
         OP_BR_NE:     taken = !is_zero;
         default:      taken = 1'b0;
      endcase
   end

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
   import acc_cpu_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       two_phase,
   output cpu_state_e state
);
   cpu_state_e nxt;

   always_comb begin
      case (state)
         ST_FETCH: nxt = ST_LATCH;
         ST_LATCH: nxt = ST_EXEC;
         ST_EXEC:  nxt = two_phase ? ST_RDATA : ST_FETCH;
         default:  nxt = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_FETCH;
      else     state <= nxt;
   end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int            DW       = 16,
   parameter int            AW       = 12,
   parameter int            OPW      = 4,
   parameter logic [AW-1:0] SP_RESET = '1
) (
   input  logic          clk,
   input  logic          rst,
   output logic [AW-1:0] mem_addr,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [AW-1:0] pc_out,
   output logic [DW-1:0] ac_out,
   output logic [AW-1:0] sp_out
);
   localparam int            PADW  = DW - AW;
   localparam logic [AW-1:0] A_ONE = AW'(1);

   // elaboration-time parameter checks
   if (OPW != 4) begin : g_opw_err
      $error("acc_cpu: opcode field must be 4 bits");
   end
   if (DW != OPW + AW) begin : g_width_err
      $error("acc_cpu: data width must equal opcode plus operand width");
   end
   if (AW < 8) begin : g_aw_err
      $error("acc_cpu: operand field must be at least 8 bits");
   end

   cpu_state_e    state_q;
   op_kind_e      op_kind;
   logic          two_phase;
   logic          take_br;
   logic [AW-1:0] ir_field;
   logic [AW-1:0] sp_step;

   logic [DW-1:0] ir_q;
   logic [DW-1:0] ac_q;
   logic [AW-1:0] pc_q;
   logic [AW-1:0] sp_q;

   logic [AW-1:0] sp_dn;
   logic [AW-1:0] sp_up;
   logic [AW-1:0] rel_ea;
   logic [AW-1:0] ind_ea;
   logic [DW-1:0] pc_ext;
   logic [DW-1:0] sp_ext;
   logic [DW-1:0] imm_ext;

   acc_cpu_seq u_seq (
      .clk       (clk),
      .rst       (rst),
      .two_phase (two_phase),
      .state     (state_q)
   );

   acc_cpu_decode #(.DW(DW), .AW(AW)) u_dec (
      .instr     (ir_q),
      .kind      (op_kind),
      .two_phase (two_phase),
      .field     (ir_field),
      .sp_step   (sp_step)
   );

   acc_cpu_cond #(.DW(DW)) u_cond (
      .ac    (ac_q),
      .kind  (op_kind),
      .taken (take_br)
   );

   always_comb begin
      sp_dn   = sp_q - A_ONE;
      sp_up   = sp_q + A_ONE;
      rel_ea  = sp_q + ir_field;
      ind_ea  = ac_q[AW-1:0];
      pc_ext  = {{PADW{1'b0}}, pc_q};
      sp_ext  = {{PADW{1'b0}}, sp_q};
      imm_ext = {{PADW{1'b0}}, ir_field};
   end

   // memory request generation
   always_comb begin
      mem_addr  = pc_q;
      mem_wdata = ac_q;
      mem_rd    = 1'b0;
      mem_wr    = 1'b0;
      case (state_q)
         ST_FETCH: mem_rd = 1'b1;
         ST_EXEC: begin
            case (op_kind)
               OP_LOAD_ABS, OP_SUB_ABS: begin mem_addr = ir_field; mem_rd = 1'b1; end
               OP_STORE_ABS:            begin mem_addr = ir_field; mem_wr = 1'b1; end
               OP_LOAD_REL, OP_SUB_REL: begin mem_addr = rel_ea;   mem_rd = 1'b1; end
               OP_STORE_REL:            begin mem_addr = rel_ea;   mem_wr = 1'b1; end
               OP_CALL: begin
                  mem_addr  = sp_dn;
                  mem_wdata = pc_ext;
                  mem_wr    = 1'b1;
               end
               OP_PUSH_AC:              begin mem_addr = sp_dn;    mem_wr = 1'b1; end
               OP_POP_AC, OP_RETURN,
               OP_POP_IND:              begin mem_addr = sp_q;     mem_rd = 1'b1; end
               OP_PUSH_IND:             begin mem_addr = ind_ea;   mem_rd = 1'b1; end
               default: ;
            endcase
         end
         ST_RDATA: begin
            case (op_kind)
               OP_PUSH_IND: begin mem_addr = sp_dn;  mem_wdata = mem_rdata; mem_wr = 1'b1; end
               OP_POP_IND:  begin mem_addr = ind_ea; mem_wdata = mem_rdata; mem_wr = 1'b1; end
               default: ;
            endcase
         end
         default: ;
      endcase
      if (rst) begin
         mem_rd = 1'b0;
         mem_wr = 1'b0;
      end
   end

   // architectural registers
   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q <= '0;
         ac_q <= '0;
         sp_q <= SP_RESET;
         ir_q <= '0;
      end else begin
         case (state_q)
            ST_FETCH: pc_q <= pc_q + A_ONE;
            ST_LATCH: ir_q <= mem_rdata;
            ST_EXEC: begin
               case (op_kind)
                  OP_LOAD_IMM: ac_q <= imm_ext;
                  OP_BR_ALWAYS, OP_BR_GT, OP_BR_EQ, OP_BR_LT, OP_BR_NE:
                     if (take_br) pc_q <= ir_field;
                  OP_CALL: begin
                     sp_q <= sp_dn;
                     pc_q <= ir_field;
                  end
                  OP_PUSH_AC:                        sp_q <= sp_dn;
                  OP_POP_AC, OP_RETURN, OP_POP_IND: sp_q <= sp_up;
                  OP_XCHG: begin
                     ac_q <= sp_ext;
                     sp_q <= ind_ea;
                  end
                  OP_SP_ADD: sp_q <= sp_q + sp_step;
                  OP_SP_SUB: sp_q <= sp_q - sp_step;
                  default: ;
               endcase
            end
            ST_RDATA: begin
               case (op_kind)
                  OP_LOAD_ABS, OP_LOAD_REL, OP_POP_AC: ac_q <= mem_rdata;
                  OP_SUB_ABS, OP_SUB_REL:              ac_q <= ac_q - mem_rdata;
                  OP_RETURN:                           pc_q <= mem_rdata[AW-1:0];
                  OP_PUSH_IND:                         sp_q <= sp_dn;
                  default: ;
               endcase
            end
            default: ;
         endcase
      end
   end

   assign pc_out = pc_q;
   assign ac_out = ac_q;
   assign sp_out = sp_q;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
   import acc_cpu_pkg::*;
#(
   parameter int            DW       = 16,
   parameter int            AW       = 12,
   parameter logic [AW-1:0] SP_RESET = '1
) (
   input logic          clk,
   input logic          rst,
   input logic          mem_rd,
   input logic          mem_wr,
   input logic [AW-1:0] mem_addr,
   input logic [AW-1:0] pc_out,
   input logic [DW-1:0] ac_out,
   input logic [AW-1:0] sp_out,
   input cpu_state_e    state,
   input op_kind_e      kind,
   input logic [AW-1:0] field
);
   localparam logic [AW-1:0] ONE = AW'(1);

   logic rst_q = 1'b0;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst_q) begin
         // R1
         reset_val_chk: assert (pc_out == '0 && ac_out == '0 && sp_out == SP_RESET)
            else $error("register value wrong after reset");
      end
      if (rst) begin
         // R1
         reset_quiet_chk: assert (!mem_rd && !mem_wr)
            else $error("memory strobe during reset");
      end
   end

   // R13
   rdwr_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

   // R2
   fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FETCH) |-> (mem_rd && mem_addr == pc_out));

   // R2
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FETCH) |=> (pc_out == $past(pc_out) + ONE));

   // R7
   call_move_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_EXEC && kind == OP_CALL) |=>
         (sp_out == $past(sp_out) - ONE) && (pc_out == $past(field)));

   // R12
   nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_EXEC && kind == OP_NOP) |-> (!mem_rd && !mem_wr));

endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW), .AW(AW), .SP_RESET(SP_RESET)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .mem_addr (mem_addr),
   .pc_out   (pc_out),
   .ac_out   (ac_out),
   .sp_out   (sp_out),
   .state    (state_q),
   .kind     (op_kind),
   .field    (ir_field)
);

// File: tb/acc_cpu_tb_top.sv
`timescale 1ns/1ps
module acc_cpu_tb_top;
   localparam int DW   = 16;
   localparam int AW   = 12;
   localparam int MEMN = 4096;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata;
   logic [DW-1:0] mem_wdata;
   logic          mem_rd;
   logic          mem_wr;
   logic [AW-1:0] pc_out;
   logic [DW-1:0] ac_out;
   logic [AW-1:0] sp_out;

   logic          ld_en   = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [DW-1:0] ld_data = '0;

   logic [DW-1:0] dmem [MEMN];
   logic [DW-1:0] rmem [MEMN];
   logic [DW-1:0] img  [MEMN];

   int checks  = 0;
   int fails   = 0;
   int overlap = 0;

   logic [AW-1:0] m_pc;
   logic [AW-1:0] m_sp;
   logic [DW-1:0] m_ac;

   acc_cpu dut_i (
      .clk       (clk),
      .rst       (rst),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .mem_wdata (mem_wdata),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .pc_out    (pc_out),
      .ac_out    (ac_out),
      .sp_out    (sp_out)
   );

   // synchronous memory with a loader port used during reset
   always @(posedge clk) begin
      if (ld_en)       dmem[ld_addr] <= ld_data;
      else if (mem_wr) dmem[mem_addr] <= mem_wdata;
      if (mem_rd)      mem_rdata <= dmem[mem_addr];
   end

   always @(negedge clk) if (!rst && mem_rd && mem_wr) overlap++;

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(logic [15:0] w);
      case (w[15:12])
         4'h0, 4'h1, 4'h3:             return "R3";
         4'h7:                         return "R4";
         4'h8, 4'h9, 4'hB:             return "R5";
         4'h4, 4'h5, 4'h6, 4'hC, 4'hD: return "R6";
         4'hE:                         return "R7";
         4'hF: begin
            if (w[11:0] == 12'h800) return "R7";
            if (w[11:0] == 12'h200 || w[11:0] == 12'h400) return "R8";
            if (w[11:0] == 12'h000 || w[11:0] == 12'h100) return "R9";
            if (w[11:0] == 12'hA00) return "R10";
            if (w[11:8] == 4'hC || w[11:8] == 4'hE) return "R11";
            return "R12";
         end
         default:                      return "R12";
      endcase
   endfunction

   // instruction-level reference model; returns the expected cycle count
   task automatic model_step(output int cyc, output string tag);
      logic [15:0] w;
      logic [11:0] x;
      logic [11:0] ea;
      logic [15:0] t;
      w   = rmem[m_pc];
      tag = tag_of(w);
      m_pc = m_pc + 12'd1;
      x   = w[11:0];
      ea  = m_sp + x;
      cyc = 3;
      case (w[15:12])
         4'h0: begin m_ac = rmem[x]; cyc = 4; end
         4'h1: rmem[x] = m_ac;
         4'h3: begin m_ac = m_ac - rmem[x]; cyc = 4; end
         4'h7: m_ac = {4'h0, x};
         4'h8: begin m_ac = rmem[ea]; cyc = 4; end
         4'h9: rmem[ea] = m_ac;
         4'hB: begin m_ac = m_ac - rmem[ea]; cyc = 4; end
         4'h4: if (!m_ac[15] && m_ac != 0) m_pc = x;
         4'h5: if (m_ac == 0) m_pc = x;
         4'hC: if (m_ac[15]) m_pc = x;
         4'hD: if (m_ac != 0) m_pc = x;
         4'h6: m_pc = x;
         4'hE: begin m_sp = m_sp - 12'd1; rmem[m_sp] = {4'h0, m_pc}; m_pc = x; end
         4'hF: begin
            if (x == 12'h000) begin
               t = rmem[m_ac[11:0]]; m_sp = m_sp - 12'd1; rmem[m_sp] = t; cyc = 4;
            end else if (x == 12'h100) begin
               rmem[m_ac[11:0]] = rmem[m_sp]; m_sp = m_sp + 12'd1; cyc = 4;
            end else if (x == 12'h200) begin
               m_sp = m_sp - 12'd1; rmem[m_sp] = m_ac;
            end else if (x == 12'h400) begin
               m_ac = rmem[m_sp]; m_sp = m_sp + 12'd1; cyc = 4;
            end else if (x == 12'h800) begin
               m_pc = rmem[m_sp][11:0]; m_sp = m_sp + 12'd1; cyc = 4;
            end else if (x == 12'hA00) begin
               t = {4'h0, m_sp}; m_sp = m_ac[11:0]; m_ac = t;
            end else if (x[11:8] == 4'hC) begin
               m_sp = m_sp + {4'h0, x[7:0]};
            end else if (x[11:8] == 4'hE) begin
               m_sp = m_sp - {4'h0, x[7:0]};
            end
         end
         default: ;
      endcase
   endtask

   task automatic clear_img();
      for (int i = 0; i < MEMN; i++) img[i] = 16'h0000;
   endtask

   task automatic fill_random();
      logic [15:0] w;
      for (int i = 0; i < MEMN; i++) begin
         w = 16'($urandom);
         if (w[15:12] == 4'hF) begin
            case ($urandom % 10)
               0: w = 16'hF000;
               1: w = 16'hF100;
               2: w = 16'hF200;
               3: w = 16'hF400;
               4: w = 16'hF800;
               5: w = 16'hFA00;
               6: w = {8'hFC, w[7:0]};
               7: w = {8'hFE, w[7:0]};
               8: w = 16'h0000;
               default: ;
            endcase
         end
         img[i] = w;
      end
   endtask

   // load image while in reset, check reset state, run in lockstep with model
   task automatic run_prog(int n, bit probe);
      int    cyc;
      int    bad;
      string tag;
      rst = 1'b1;
      @(negedge clk);
      for (int i = 0; i < MEMN; i++) begin
         ld_en   = 1'b1;
         ld_addr = AW'(i);
         ld_data = img[i];
         rmem[i] = img[i];
         @(negedge clk);
      end
      ld_en = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1", "pc", 32'(pc_out), 32'h0);
      chk("R1", "ac", 32'(ac_out), 32'h0);
      chk("R1", "sp", 32'(sp_out), 32'hFFF);
      chk("R1", "rd/wr", {30'h0, mem_rd, mem_wr}, 32'h0);
      m_pc = '0; m_ac = '0; m_sp = 12'hFFF;
      rst = 1'b0;
      for (int k = 0; k < n; k++) begin
         model_step(cyc, tag);
         if (probe && k == 0) begin
            repeat (cyc - 1) @(posedge clk);
            @(negedge clk);
            // R2: result not visible before the last cycle of the instruction
            chk("R2", "ac early", 32'(ac_out), 32'h0);
            @(posedge clk);
         end else begin
            repeat (cyc) @(posedge clk);
         end
         @(negedge clk);
         chk(tag, "pc", 32'(pc_out), 32'(m_pc));
         chk(tag, "ac", 32'(ac_out), 32'(m_ac));
         chk(tag, "sp", 32'(sp_out), 32'(m_sp));
      end
      bad = 0;
      for (int i = 0; i < MEMN; i++) if (dmem[i] !== rmem[i]) bad++;
      chk("R3", "memory mismatches", 32'(bad), 32'h0);
      rst = 1'b1;
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0A11));

      // program A: absolute access, branches, unlisted codes (R3 R4 R6 R12)
      clear_img();
      img[0]  = 16'h7005; img[1]  = 16'h1100; img[2]  = 16'h3101;
      img[3]  = 16'hC006; img[4]  = 16'h7111; img[5]  = 16'h0000;
      img[6]  = 16'h5009; img[7]  = 16'h4009; img[8]  = 16'hD00A;
      img[9]  = 16'h6009; img[10] = 16'h0100; img[11] = 16'h400D;
      img[12] = 16'h0000; img[13] = 16'h2123; img[14] = 16'hA456;
      img[15] = 16'hF300; img[16] = 16'hF201; img[17] = 16'h6011;
      img[16'h101] = 16'h0007;
      run_prog(20, 1'b1);

      // program B: call/return, stack, indirect, swap, SP adjust (R5 R7-R11)
      clear_img();
      img[0]  = 16'h7042; img[1]  = 16'hF200; img[2]  = 16'hE010;
      img[3]  = 16'hF400; img[4]  = 16'hFC01; img[5]  = 16'h8005;
      img[6]  = 16'hFE03; img[7]  = 16'hFA00; img[8]  = 16'h7200;
      img[9]  = 16'hF000; img[10] = 16'h7300; img[11] = 16'hF100;
      img[12] = 16'h0300; img[13] = 16'h600D;
      img[16'h10] = 16'h8001; img[16'h11] = 16'h7077; img[16'h12] = 16'h9002;
      img[16'h13] = 16'hB002; img[16'h14] = 16'hF800;
      img[16'h200] = 16'hBEEF;
      run_prog(22, 1'b0);

      // program C: SP wrap in both directions (R5 R8 R11)
      clear_img();
      img[0] = 16'hFC01; img[1] = 16'h7ABC; img[2] = 16'hF200;
      img[3] = 16'hF400; img[4] = 16'h9FFF; img[5] = 16'hFEFF;
      img[6] = 16'hFCFF; img[7] = 16'h6007;
      run_prog(10, 1'b0);

      // random programs
      for (int p = 0; p < 6; p++) begin
         fill_random();
         run_prog(300, 1'b0);
      end

      // R13 strobes never together
      chk("R13", "rd&wr overlap cycles", 32'(overlap), 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule